// File: doc/BRIEF.md
# Successive-Approximation Serial Conversion Sequencer

This block is the digital controller of a 12-bit successive-approximation converter whose result leaves on a three-wire serial link. It runs on the serial clock. An active-low select starts each conversion, and a shutdown input aborts one. It drives the trial code to the capacitor DAC and reads back a single comparator decision on every conversion clock. It shifts the result out as a 16-bit word that begins with four zero bits. It also drives a busy flag, a sample/hold control and a tri-state enable for the data pin.

Two operating styles are supported. In select-per-word mode, every falling edge of the select starts one word. After the last bit the pin holds its value until the select is released. In continuous mode, the select stays low and the block repeats a 17-clock cycle on its own: 16 data clocks and one idle clock. The comparator, DAC and reference lie outside the block. For checking, the finished code is also presented on a parallel port with a one-cycle strobe.

Top module: `sar_serial_seq`

## Requirements
- R1: While cs_n is high, the block is cleared without waiting for a clock: dout_oe, status and hold are low, dac_code is 0x800, and any conversion in progress is abandoned. The next falling edge of cs_n starts a fresh, correct conversion.
- R2: When cs_n falls with shdn low, status, hold and dout_oe go high at once, and dout reads 0 before the first rising edge of sclk.
- R3: The serial bit numbered n (1 to 16) is valid at the n-th rising edge after a word starts. Bits 1 to 4 are 0, and bits 5 to 16 carry result bits 11 down to 0.
- R4: dout changes only on falling edges of sclk. Its value just after a rising edge equals its value just before that edge.
- R5: The trial code starts at 0x800. At rising edge j (j = 1 to 12), bit 12-j stays set if comp is 1 and is cleared if comp is 0, and the next lower bit is set. With a monotonic comparator, the final code is the input level.
- R6: result_vld is high for exactly the one cycle after the 12th rising edge of a word. During that cycle, result holds the finished code and dac_code equals result.
- R7: With free_run low, status falls on the falling edge after the 16th rising edge. dout then keeps the last data bit, and no further conversion or strobe occurs until cs_n rises and falls again.
- R8: With free_run high and cs_n low, words repeat every 17 clocks. status is low at exactly one rising edge (the 17th), dout is 0 in that idle slot, and the next word carries a new conversion.
- R9: A high level on shdn aborts and clears the block exactly as R1 does, whatever the state of cs_n.
- R10: rst_n low at a rising edge clears the sequence: dac_code returns to 0x800, dout to 0, and result and result_vld to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; logic on both edges |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low select; high clears, falling edge starts |
| shdn | input | 1 | Shutdown; high clears asynchronously |
| free_run | input | 1 | 1 = continuous 17-clock cycle, 0 = one word per select |
| comp | input | 1 | Comparator decision: 1 = input at or above dac_code |
| dac_code | output | 12 | Trial code to the DAC |
| dout | output | 1 | Serial data, valid when dout_oe is high |
| dout_oe | output | 1 | Tri-state enable for the data pin |
| status | output | 1 | High while a conversion is in progress |
| hold | output | 1 | 1 = sample/hold in hold, 0 = acquire |
| result | output | 12 | Last finished code |
| result_vld | output | 1 | One-cycle strobe for result |

## Verification
The hardest situation to reach is an abort in the middle of a word, followed by a clean restart. It needs cs_n or shdn to change between two clock edges after only a few bits have left. The bench reaches it by capturing a partial word, then lifting the control line at a fixed offset after a rising edge. It checks the cleared outputs before the next edge, then runs a full word with a different input level. The continuous-mode idle slot is reached by leaving cs_n low across two whole words, changing the comparator level during the idle clock, and sampling status around the 17th edge.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial conversion sequencer.
package sar_seq_pkg;
    // Selects what the data pin takes at a falling edge.
    typedef enum logic [1:0] {
        SRC_ZERO = 2'd0,
        SRC_BIT  = 2'd1,
        SRC_KEEP = 2'd2
    } dout_src_e;
endpackage

// File: rtl/sar_seq_frame_ctr.sv
`timescale 1ns/1ps
// Word position counter. 0 = armed, 1..FRAME_LEN = rising edges seen,
// FRAME_LEN+1 = idle clock of continuous mode.
// Assumes clr is the combined asynchronous clear (select high or shutdown).
module sar_seq_frame_ctr #(
    parameter int FRAME_LEN = 16,
    parameter int CNT_W     = 5
) (
    input  logic             sclk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             free_run,
    output logic [CNT_W-1:0] pos
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] IDLE = CNT_W'(FRAME_LEN + 1);

    // Advance one step per rising edge; saturate or wrap after the last bit.
    always_ff @(posedge sclk or posedge clr) begin
        if (clr) begin
            pos <= '0;
        end else if (!rst_n) begin
            pos <= '0;
        end else if (pos == IDLE) begin
            pos <= CNT_W'(1);
        end else if (pos == LAST) begin
            pos <= free_run ? IDLE : LAST;
        end else begin
            pos <= pos + 1'b1;
        end
    end
endmodule

// File: rtl/sar_seq_sar_reg.sv
`timescale 1ns/1ps
// Successive-approximation register. One decision per rising edge while
// pos is below RES_BITS (or in the idle slot, which begins the next word).
// Assumes comp settles against sar within the clock period.
module sar_seq_sar_reg #(
    parameter int RES_BITS  = 12,
    parameter int FRAME_LEN = 16,
    parameter int CNT_W     = 5
) (
    input  logic                sclk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                free_run,
    input  logic                comp,
    input  logic [CNT_W-1:0]    pos,
    output logic [RES_BITS-1:0] sar,
    output logic [RES_BITS-1:0] result,
    output logic                done
);
    localparam logic [RES_BITS-1:0] TRIAL0 = {1'b1, {(RES_BITS-1){1'b0}}};
    localparam logic [CNT_W-1:0]    LAST   = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0]    IDLE   = CNT_W'(FRAME_LEN + 1);

    logic                decide;
    logic                last_dec;
    int                  bidx;
    logic [RES_BITS-1:0] sar_nx;

    // Work out which bit is decided now and the register's next value.
    always_comb begin
        decide   = (pos == IDLE) || (pos < CNT_W'(RES_BITS));
        bidx     = (pos == IDLE) ? (RES_BITS - 1) : (RES_BITS - 1 - int'(pos));
        last_dec = decide && (bidx == 0);
        sar_nx   = sar;
        if (decide) begin
            for (int i = 0; i < RES_BITS; i++) begin
                if (i == bidx)     sar_nx[i] = comp;
                if (i == bidx - 1) sar_nx[i] = 1'b1;
            end
        end
    end

    // Trial register with its strobe; reloads before each continuous word.
    always_ff @(posedge sclk or posedge clr) begin
        if (clr) begin
            sar  <= TRIAL0;
            done <= 1'b0;
        end else if (!rst_n) begin
            sar  <= TRIAL0;
            done <= 1'b0;
        end else begin
            done <= last_dec;
            if (pos == LAST && free_run) sar <= TRIAL0;
            else                         sar <= sar_nx;
        end
    end

    // Parallel copy of the finished code; kept across select releases.
    always_ff @(posedge sclk) begin
        if (!rst_n)        result <= '0;
        else if (last_dec) result <= sar_nx;
    end
endmodule

// File: rtl/sar_seq_shifter.sv
`timescale 1ns/1ps
// Falling-edge output stage: leading zeros, then code MSB first, then hold
// (one word per select) or zero (continuous). Also keeps the tail flag that
// ends the busy indication. Assumes every code bit shown at position p
// was decided at or before rising edge p (needs LEAD_ZEROS >= 1).
module sar_seq_shifter
    import sar_seq_pkg::*;
#(
    parameter int RES_BITS   = 12,
    parameter int LEAD_ZEROS = 4,
    parameter int FRAME_LEN  = 16,
    parameter int CNT_W      = 5
) (
    input  logic                sclk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                free_run,
    input  logic [CNT_W-1:0]    pos,
    input  logic [RES_BITS-1:0] sar,
    output logic                dout,
    output logic                tail
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] IDLE = CNT_W'(FRAME_LEN + 1);

    dout_src_e src;
    logic      pick;

    // Choose the next pin value from the word position.
    always_comb begin
        src  = SRC_ZERO;
        pick = 1'b0;
        if (pos == LAST) begin
            src = free_run ? SRC_ZERO : SRC_KEEP;
        end else if (pos >= CNT_W'(LEAD_ZEROS) && pos < LAST) begin
            src = SRC_BIT;
            for (int i = 0; i < RES_BITS; i++) begin
                if (int'(pos) == FRAME_LEN - 1 - i) pick = sar[i];
            end
        end
    end

    // Update the pin and the tail flag on the falling edge.
    always_ff @(negedge sclk or posedge clr) begin
        if (clr) begin
            dout <= 1'b0;
            tail <= 1'b0;
        end else if (!rst_n) begin
            dout <= 1'b0;
            tail <= 1'b0;
        end else begin
            case (src)
                SRC_ZERO: dout <= 1'b0;
                SRC_BIT:  dout <= pick;
                default:  dout <= dout;
            endcase
            if (pos == LAST)      tail <= 1'b1;
            else if (pos == IDLE) tail <= 1'b0;
        end
    end
endmodule

// File: rtl/sar_serial_seq.sv
`timescale 1ns/1ps
// Top of the conversion sequencer. Combines select and shutdown into one
// asynchronous clear and wires the counter, the approximation register and
// the output stage. Assumes sclk is free running while a word is in flight.
module sar_serial_seq #(
    parameter int RES_BITS   = 12,
    parameter int LEAD_ZEROS = 4
) (
    input  logic                sclk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                shdn,
    input  logic                free_run,
    input  logic                comp,
    output logic [RES_BITS-1:0] dac_code,
    output logic                dout,
    output logic                dout_oe,
    output logic                status,
    output logic                hold,
    output logic [RES_BITS-1:0] result,
    output logic                result_vld
);
    localparam int FRAME_LEN = RES_BITS + LEAD_ZEROS;
    localparam int CNT_W     = $clog2(FRAME_LEN + 2);

    logic             clr;
    logic             tail;
    logic [CNT_W-1:0] pos;

    assign clr      = cs_n | shdn;
    assign dout_oe  = ~clr;
    assign status   = ~clr & ~tail;
    assign hold     = status;

    sar_seq_frame_ctr #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) ctr_i (
        .sclk(sclk), .rst_n(rst_n), .clr(clr), .free_run(free_run), .pos(pos)
    );

    sar_seq_sar_reg #(.RES_BITS(RES_BITS), .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) sar_i (
        .sclk(sclk), .rst_n(rst_n), .clr(clr), .free_run(free_run), .comp(comp),
        .pos(pos), .sar(dac_code), .result(result), .done(result_vld)
    );

    sar_seq_shifter #(.RES_BITS(RES_BITS), .LEAD_ZEROS(LEAD_ZEROS),
                      .FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) shf_i (
        .sclk(sclk), .rst_n(rst_n), .clr(clr), .free_run(free_run), .pos(pos),
        .sar(dac_code), .dout(dout), .tail(tail)
    );
endmodule

// File: rtl/sar_serial_seq_chk.sv
`timescale 1ns/1ps
// Port-level properties of the sequencer, attached by bind.
module sar_serial_seq_chk #(
    parameter int RES_BITS = 12
) (
    input logic                sclk,
    input logic                rst_n,
    input logic                cs_n,
    input logic                shdn,
    input logic                free_run,
    input logic [RES_BITS-1:0] dac_code,
    input logic                dout,
    input logic                dout_oe,
    input logic                status,
    input logic [RES_BITS-1:0] result,
    input logic                result_vld
);
    localparam logic [RES_BITS-1:0] TRIAL0 = {1'b1, {(RES_BITS-1){1'b0}}};

    // R1
    cs_clear_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (cs_n || shdn) |-> (!dout_oe && !status && dac_code == TRIAL0));

    // R2
    start_state_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (dout_oe && !$past(dout_oe)) |-> (status && dac_code == TRIAL0));

    // R6
    strobe_width_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        result_vld |=> !result_vld);

    // R6
    strobe_code_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        result_vld |-> (dac_code == result));

    // R7
    slave_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (!free_run && dout_oe && !status) |=> (cs_n || shdn || (!status && $stable(dout))));

    // R8
    idle_slot_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (free_run && dout_oe && !status) |=> (!dout_oe || status));
endmodule

bind sar_serial_seq sar_serial_seq_chk #(.RES_BITS(RES_BITS)) chk_i (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .shdn(shdn), .free_run(free_run),
    .dac_code(dac_code), .dout(dout), .dout_oe(dout_oe), .status(status),
    .result(result), .result_vld(result_vld)
);

// File: tb/sar_serial_seq_tb_top.sv
`timescale 1ns/1ps
module sar_serial_seq_tb_top;
    logic        sclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        shdn = 1'b0;
    logic        free_run = 1'b0;
    logic [11:0] vin = 12'h000;
    logic        comp;
    logic [11:0] dac_code, result;
    logic        dout, dout_oe, status, hold, result_vld;

    always #4 sclk = ~sclk;

    // Ideal comparator model
    assign comp = (vin >= dac_code);

    sar_serial_seq dut_i (
        .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .shdn(shdn), .free_run(free_run),
        .comp(comp), .dac_code(dac_code), .dout(dout), .dout_oe(dout_oe),
        .status(status), .hold(hold), .result(result), .result_vld(result_vld)
    );

    int n_chk = 0;
    int n_fail = 0;

    // {input level, expected 16-bit word}
    localparam logic [27:0] VEC [8] = '{
        {12'h000, 16'h0000}, {12'hFFF, 16'h0FFF}, {12'h800, 16'h0800},
        {12'h7FF, 16'h07FF}, {12'h555, 16'h0555}, {12'hAAA, 16'h0AAA},
        {12'h001, 16'h0001}, {12'h9C3, 16'h09C3}
    };

    logic [15:0] g_word;
    int          g_vld_cnt, g_vld_at;
    logic [11:0] g_res;
    bit          g_busy_ok, g_edge_ok;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic open_word();
        @(posedge sclk); #1 cs_n = 1'b0;
    endtask

    // Sample nbits serial bits just before each rising edge.
    task grab(input int nbits);
        logic b;
        g_word = '0; g_vld_cnt = 0; g_vld_at = -1; g_res = '0;
        g_busy_ok = 1'b1; g_edge_ok = 1'b1;
        for (int n = 0; n < nbits; n++) begin
            @(negedge sclk); #3;
            b = dout;
            g_word = {g_word[14:0], b};
            if (!status || !hold || !dout_oe) g_busy_ok = 1'b0;
            if (result_vld) begin
                g_vld_cnt++; g_vld_at = n; g_res = result;
            end
            @(posedge sclk); #1;
            if (dout != b) g_edge_ok = 1'b0;
        end
    endtask

    task automatic full_word_checks(input logic [11:0] lvl, input string tag);
        check(g_word == {4'h0, lvl}, {tag, " R3 R5 word"}, 32'(g_word), 32'({4'h0, lvl}));
        check(g_busy_ok, {tag, " R2 busy during word"}, 32'(g_busy_ok), 32'd1);
        check(g_edge_ok, {tag, " R4 stable across rising edge"}, 32'(g_edge_ok), 32'd1);
        check(g_vld_cnt == 1 && g_vld_at == 12, {tag, " R6 strobe timing"},
              32'(g_vld_at), 32'd12);
        check(g_res == lvl, {tag, " R6 parallel code"}, 32'(g_res), 32'(lvl));
    endtask

    initial begin
        repeat (3) @(posedge sclk);
        #1;
        // R10 reset state
        check(!dout_oe && !status && !hold && !result_vld && result == 12'h000,
              "R10 reset state", {dout_oe, status, hold, result_vld, 16'(result)}, 32'd0);
        check(dac_code == 12'h800, "R1 idle trial code", 32'(dac_code), 32'h800);
        @(negedge sclk); rst_n = 1'b1;

        // Table walk, one word per select
        for (int k = 0; k < 8; k++) begin
            vin = VEC[k][27:16];
            open_word();
            grab(16);
            check(g_word == VEC[k][15:0], "R3 table word", 32'(g_word), 32'(VEC[k][15:0]));
            full_word_checks(VEC[k][27:16], "table");
            @(negedge sclk); #3;
            check(!status && !hold, "R7 busy ends after bit 16", 32'(status), 32'd0);
            cs_n = 1'b1;
            #2;
            check(!dout_oe && !status, "R1 release tri-states", {dout_oe, status}, 32'd0);
        end

        // R7 hold after the last bit
        vin = 12'h555;
        open_word();
        grab(16);
        full_word_checks(12'h555, "hold");
        begin
            bit ok = 1'b1;
            for (int c = 0; c < 20; c++) begin
                @(negedge sclk); #3;
                if (dout !== 1'b1 || status || !dout_oe || result_vld) ok = 1'b0;
            end
            check(ok, "R7 pin holds last bit, no restart", 32'(ok), 32'd1);
        end
        cs_n = 1'b1;

        // R1 abort by select mid-word, then clean restart
        vin = 12'h3C5;
        open_word();
        grab(6);
        cs_n = 1'b1;
        #2;
        check(!dout_oe && !status && !hold && dac_code == 12'h800, "R1 abort clears",
              {dout_oe, status, hold, 1'b0, 16'(dac_code)}, 32'h800);
        vin = 12'h246;
        open_word();
        grab(16);
        full_word_checks(12'h246, "R1 restart");
        cs_n = 1'b1;

        // R9 shutdown mid-word
        vin = 12'hFFF;
        open_word();
        grab(9);
        shdn = 1'b1;
        #2;
        check(!dout_oe && !status && !hold && dac_code == 12'h800, "R9 shutdown clears",
              {dout_oe, status, hold, 1'b0, 16'(dac_code)}, 32'h800);
        cs_n = 1'b1;
        #10 shdn = 1'b0;
        vin = 12'h6B1;
        open_word();
        grab(16);
        full_word_checks(12'h6B1, "R9 restart");
        cs_n = 1'b1;

        // R10 synchronous reset mid-word
        vin = 12'hABC;
        open_word();
        grab(8);
        rst_n = 1'b0;
        @(posedge sclk);
        @(negedge sclk); #3;
        check(dac_code == 12'h800 && dout == 1'b0 && !result_vld, "R10 mid-word reset",
              {dout, result_vld, 14'd0, 16'(dac_code)}, 32'h800);
        rst_n = 1'b1;
        cs_n = 1'b1;

        // R8 continuous mode over two words
        free_run = 1'b1;
        vin = 12'h3A7;
        open_word();
        grab(16);
        full_word_checks(12'h3A7, "R8 word 1");
        @(negedge sclk); #3;
        check(!status && dout == 1'b0 && dout_oe, "R8 idle slot",
              {status, dout, dout_oe}, 32'b001);
        vin = 12'hC58;
        grab(16);
        full_word_checks(12'hC58, "R8 word 2");
        @(negedge sclk); #3;
        check(!status && dout == 1'b0, "R8 second idle slot", {status, dout}, 32'd0);
        grab(1);
        check(g_busy_ok, "R8 one idle clock only", 32'(g_busy_ok), 32'd1);
        cs_n = 1'b1;
        free_run = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge sclk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule